// File: doc/BRIEF.md
# Gated Frequency Counter with Source Select

This block measures the frequency of one of three asynchronous input signals: an FM oscillator tap, an IF oscillator tap and a stereo decoder clock. Software or a control sequencer picks a source with a one-hot select, gives a gate length in milliseconds and a scale factor, then pulses `start`. The block clears its edge counter and counts rising edges of the chosen input for exactly the gate length. It then computes a scaled rate and raises `done` for one cycle.

The raw 16-bit count is readable as a high byte and a low byte. The count stops at its maximum instead of wrapping. The scaled result divides the count times the scale by the gate length in milliseconds. When the FM source is selected, the result is also multiplied by a prescale of 256, so that it reads directly in the oscillator's own units. Each measured input passes through a two-flop synchronizer into the system clock domain before its edges are detected. The number of system clocks per millisecond is a parameter.

Top module: `freq_gate_counter`

## Requirements
- R1: After reset, `busy` and `done` are 0, and `count_hi`, `count_lo` and `result` are all 0.
- R2: `src_sel` is one-hot. Bit 0 selects `sig_if`, bit 1 selects `sig_fm` and bit 2 selects `sig_sd`. Only rising edges of the selected input are counted, and edges on the other two inputs have no effect on the count.
- R3: A `start` is accepted only while idle, only when exactly one bit of `src_sel` is set, and only when `gate_ms` is nonzero. Any other `start` leaves `busy` low and leaves the count and result unchanged.
- R4: An accepted start clears the count to zero. Rising edges are then counted for exactly `gate_ms` × `CLKS_PER_MS` clock cycles.
- R5: `count_hi` carries bits 15..8 of the count and `count_lo` carries bits 7..0. Both hold their value while the block is idle.
- R6: The count saturates at 0xFFFF and never wraps.
- R7: When `done` is high, `result` equals floor(count × scale × 256 / gate_ms) for the FM source. For the IF and stereo sources it equals floor(count × scale / gate_ms).
- R8: `busy` stays high from the accepted start until the measurement ends. `done` is a one-cycle pulse in the first cycle after `busy` falls.
- R9: While `busy` is high, changes on `start`, `src_sel`, `gate_ms` and `scale` are ignored. The values captured at acceptance are used for the whole measurement.
- R10: A pulse on the selected input that is high for at least one clock and then low for at least one clock is counted exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a measurement |
| src_sel | input | 3 | One-hot source select (bit 0 IF, bit 1 FM, bit 2 stereo clock) |
| gate_ms | input | GATE_W | Gate length in milliseconds |
| scale | input | SCALE_W | Multiplier applied to the count |
| sig_if | input | 1 | IF oscillator input, asynchronous |
| sig_fm | input | 1 | FM oscillator input, asynchronous |
| sig_sd | input | 1 | Stereo decoder clock input, asynchronous |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | One-cycle pulse when `result` is valid |
| count_hi | output | 8 | Upper byte of the edge count |
| count_lo | output | 8 | Lower byte of the edge count |
| result | output | 16+SCALE_W+8 | Scaled frequency result |

## Verification
The hardest state to reach is saturation. More than 65535 synchronized rising edges must fall inside one gate, so the bench runs a 128 ms gate with a reduced clocks-per-millisecond parameter and drives the FM input with a square wave that toggles every cycle. Exact counts elsewhere come from bursts of single-cycle pulses placed well inside the gate, while the non-selected inputs receive extra pulses. The gate length itself is checked with a free-running wave whose expected edge count is known to within one edge.

// File: rtl/fgc_pkg.sv
package fgc_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int NSRC   = 3;
  localparam int SRC_IF = 0;
  localparam int SRC_FM = 1;
  localparam int SRC_SD = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GATE = 2'd1,
    ST_LOAD = 2'd2,
    ST_DIV  = 2'd3
  } fgc_state_t;
endpackage

// File: rtl/fgc_edge_sync.sv
module fgc_edge_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] sig_in,
  output logic [N-1:0] rise
);
  for (genvar g = 0; g < N; g++) begin : g_lane
    logic [2:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[1:0], sig_in[g]};
    end
    assign rise[g] = sh[1] & ~sh[2];
  end
endmodule

// File: rtl/fgc_sat_counter.sv
module fgc_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;
  always_ff @(posedge clk) begin
    if (rst || clr)            cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/fgc_divider.sv
module fgc_divider #(
  parameter int NUM_W = 40,
  parameter int DEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quot
);
  localparam int LC_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem, den_q;
  logic [NUM_W-1:0] q;
  logic [LC_W-1:0]  left;
  logic             active;
  logic [DEN_W:0]   trial;
  logic             fits;

  assign trial = {rem, q[NUM_W-1]};
  assign fits  = trial >= {1'b0, den_q};
  assign quot  = q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem    <= '0;
      den_q  <= '0;
      q      <= '0;
      left   <= '0;
      active <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        q      <= num;
        rem    <= '0;
        den_q  <= den;
        left   <= LC_W'(NUM_W);
        active <= 1'b1;
      end else if (active) begin
        rem  <= fits ? DEN_W'(trial - {1'b0, den_q}) : DEN_W'(trial);
        q    <= {q[NUM_W-2:0], fits};
        left <= left - 1'b1;
        if (left == LC_W'(1)) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/freq_gate_counter.sv
module freq_gate_counter
  import fgc_pkg::*;
#(
  parameter int CLKS_PER_MS = 50000,
  parameter int GATE_W      = 8,
  parameter int SCALE_W     = 16,
  parameter int FM_SHIFT    = 8,
  localparam int RES_W      = CNT_W + SCALE_W + FM_SHIFT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [NSRC-1:0]    src_sel,
  input  logic [GATE_W-1:0]  gate_ms,
  input  logic [SCALE_W-1:0] scale,
  input  logic               sig_if,
  input  logic               sig_fm,
  input  logic               sig_sd,
  output logic               busy,
  output logic               done,
  output logic [BYTE_W-1:0]  count_hi,
  output logic [BYTE_W-1:0]  count_lo,
  output logic [RES_W-1:0]   result
);
  localparam int TMR_W  = GATE_W + $clog2(CLKS_PER_MS + 1);
  localparam int PROD_W = CNT_W + SCALE_W;

  fgc_state_t         st;
  logic [NSRC-1:0]    sel_q;
  logic [GATE_W-1:0]  gate_q;
  logic [SCALE_W-1:0] scale_q;
  logic [TMR_W-1:0]   tmr;
  logic [NSRC-1:0]    rise;
  logic [CNT_W-1:0]   cnt;
  logic [PROD_W-1:0]  prod;
  logic [RES_W-1:0]   num;
  logic [RES_W-1:0]   div_quot;
  logic               div_done;
  logic               accept;
  logic               inc;

  assign accept = (st == ST_IDLE) && start && $onehot(src_sel) && (gate_ms != '0);
  assign inc    = (st == ST_GATE) && |(rise & sel_q);
  assign prod   = PROD_W'(cnt) * PROD_W'(scale_q);
  assign num    = sel_q[SRC_FM] ? {prod, {FM_SHIFT{1'b0}}} : {{FM_SHIFT{1'b0}}, prod};

  fgc_edge_sync #(.N(NSRC)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .sig_in ({sig_sd, sig_fm, sig_if}),
    .rise   (rise)
  );

  fgc_sat_counter #(.W(CNT_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (accept),
    .inc (inc),
    .cnt (cnt)
  );

  fgc_divider #(.NUM_W(RES_W), .DEN_W(GATE_W)) u_div (
    .clk   (clk),
    .rst   (rst),
    .start (st == ST_LOAD),
    .num   (num),
    .den   (gate_q),
    .done  (div_done),
    .quot  (div_quot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      sel_q   <= '0;
      gate_q  <= '0;
      scale_q <= '0;
      tmr     <= '0;
      result  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (accept) begin
          st      <= ST_GATE;
          sel_q   <= src_sel;
          gate_q  <= gate_ms;
          scale_q <= scale;
          tmr     <= TMR_W'(gate_ms) * TMR_W'(CLKS_PER_MS) - TMR_W'(1);
        end
        ST_GATE: begin
          if (tmr == '0) st <= ST_LOAD;
          else           tmr <= tmr - 1'b1;
        end
        ST_LOAD: st <= ST_DIV;
        ST_DIV: if (div_done) begin
          st     <= ST_IDLE;
          result <= div_quot;
          done   <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (st != ST_IDLE);
  assign count_hi = cnt[CNT_W-1 -: BYTE_W];
  assign count_lo = cnt[BYTE_W-1:0];
endmodule

// File: rtl/fgc_checker.sv
module fgc_checker #(
  parameter int GATE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [2:0]        src_sel,
  input logic [GATE_W-1:0] gate_ms,
  input logic              busy,
  input logic              done,
  input logic [7:0]        count_hi,
  input logic [7:0]        count_lo
);
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  a_r8_busy_until_done: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done));

  a_r3_reject_invalid: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && (!$onehot(src_sel) || gate_ms == '0)) |=> !busy);

  a_r5_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |=> (busy || $stable({count_hi, count_lo})));

  a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ({count_hi, count_lo} >= $past({count_hi, count_lo})));
endmodule

bind freq_gate_counter fgc_checker #(.GATE_W(GATE_W)) u_fgc_checker (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .src_sel  (src_sel),
  .gate_ms  (gate_ms),
  .busy     (busy),
  .done     (done),
  .count_hi (count_hi),
  .count_lo (count_lo)
);

// File: tb/test_freq_gate_counter.sv
module test_freq_gate_counter;
  localparam int CPM = 1030;
  localparam int RW  = 16 + 16 + 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [2:0]    src_sel = '0;
  logic [7:0]    gate_ms = '0;
  logic [15:0]   scale = '0;
  logic          busy, done;
  logic [7:0]    count_hi, count_lo;
  logic [RW-1:0] result;

  logic [2:0] pmask = '0;
  logic [2:0] w_en  = '0;
  int         w_per = 2;
  int         w_cnt = 0;
  logic       w_sig;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  always @(negedge clk) w_cnt <= (w_cnt + 1 >= w_per) ? 0 : w_cnt + 1;
  assign w_sig = (w_cnt < w_per / 2);

  freq_gate_counter #(.CLKS_PER_MS(CPM)) i_freq_gate_counter (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .src_sel  (src_sel),
    .gate_ms  (gate_ms),
    .scale    (scale),
    .sig_if   (pmask[0] | (w_en[0] & w_sig)),
    .sig_fm   (pmask[1] | (w_en[1] & w_sig)),
    .sig_sd   (pmask[2] | (w_en[2] & w_sig)),
    .busy     (busy),
    .done     (done),
    .count_hi (count_hi),
    .count_lo (count_lo),
    .result   (result)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_res(input logic [2:0] sel, input longint n,
                                     input longint scl, input longint g);
    return (n * scl * (sel == 3'b010 ? 256 : 1)) / g;
  endfunction

  function automatic longint cnt_now();
    return longint'({count_hi, count_lo});
  endfunction

  task automatic emit(input logic [2:0] m1, input int n1, input logic [2:0] m2, input int n2);
    for (int i = 0; i < n1 + n2; i++) begin
      pmask = (i < n1) ? m1 : m2;
      @(negedge clk);
      pmask = '0;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic kick(input logic [2:0] sel, input int g, input int scl);
    @(negedge clk);
    src_sel = sel;
    gate_ms = 8'(g);
    scale   = 16'(scl);
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic measure(input logic [2:0] sel, input int g, input int scl,
                         input int n, input int n_oth, input string req);
    kick(sel, g, scl);
    repeat (3) @(negedge clk);
    emit(3'b111, n, ~sel, n_oth);
    wait_done();
    chk({req, " count"}, cnt_now(), n);
    chk({req, " result R7"}, longint'(result), exp_res(sel, n, scl, g));
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    longint prev;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 count", cnt_now(), 0);
    chk("R1 result", longint'(result), 0);

    // R2 R10 FM source, other inputs pulsed more
    measure(3'b010, 1, 1, 100, 40, "R2 R10 fm");
    chk("R8 busy low at done", busy, 0);
    @(negedge clk);
    chk("R8 done single", done, 0);

    measure(3'b001, 2, 1000, 77, 50, "R2 if");
    // R5 byte split: 300 = 0x012C
    measure(3'b100, 1, 7, 300, 10, "R2 sd");
    chk("R5 count_hi", count_hi, 1);
    chk("R5 count_lo", count_lo, 44);
    // R4 clear between runs
    measure(3'b010, 3, 5, 5, 20, "R4 clear");

    // sweep over sources and gate lengths
    for (int s = 0; s < 3; s++)
      for (int g = 1; g <= 3; g++)
        measure(3'(1 << s), g, 3 * g + s + 1, 37 * g + 11 * s + 3, 20, "R2 R7 sweep");

    // R3 invalid starts
    prev = cnt_now();
    kick(3'b011, 2, 1);
    emit(3'b111, 3, 3'b000, 0);
    chk("R3 two bits busy", busy, 0);
    chk("R3 two bits count", cnt_now(), prev);
    kick(3'b000, 2, 1);
    repeat (3) @(negedge clk);
    chk("R3 no bits busy", busy, 0);
    kick(3'b010, 0, 1);
    emit(3'b111, 3, 3'b000, 0);
    chk("R3 zero gate busy", busy, 0);
    chk("R3 zero gate count", cnt_now(), prev);
    chk("R3 zero gate result", longint'(result), exp_res(3'b100, 37 * 3 + 22 + 3, 12, 3));

    // R9 changes while busy are ignored
    kick(3'b010, 2, 3);
    repeat (3) @(negedge clk);
    src_sel = 3'b001;
    gate_ms = 8'd5;
    scale   = 16'd9;
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    emit(3'b011, 40, 3'b001, 60);
    wait_done();
    chk("R9 count", cnt_now(), 40);
    chk("R9 result", longint'(result), 15360);

    // R4 gate length: period-4 wave on IF during a 1 ms gate
    w_per = 4;
    w_en  = 3'b001;
    kick(3'b001, 1, 1);
    wait_done();
    prev = cnt_now();
    total++;
    if (prev < CPM / 4 || prev > CPM / 4 + 1) begin
      bad++;
      $display("FAIL R4 gate window actual=%0d expected=%0d..%0d", prev, CPM / 4, CPM / 4 + 1);
    end
    chk("R7 unit result", longint'(result), prev);
    repeat (20) @(negedge clk);
    chk("R5 hold idle", cnt_now(), prev);
    w_en = '0;

    // R6 saturation: toggling FM for a 128 ms gate
    w_per = 2;
    w_en  = 3'b010;
    kick(3'b010, 128, 1);
    wait_done();
    w_en = '0;
    chk("R6 saturate", cnt_now(), 65535);
    chk("R6 R7 saturated result", longint'(result), 131070);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule